// File: doc/BRIEF.md
# Coprocessor Message Mailbox Controller

This block moves complete messages between a host register interface and an external coprocessor. Both sides see a shared 2 KB on-chip buffer RAM. The first kilobyte is divided into four 256-byte slots. Byte 0 of a slot holds the message length, and the payload follows from byte 1.

To send a message, the host fills a transmit slot through a second RAM port, selects that slot and writes the send register. The block then streams the length byte and the payload bytes to the coprocessor, and raises a sent flag when the last byte is accepted. When the coprocessor raises its data-ready line, the block fetches one length-prefixed message into the selected receive slot. It then sets a received flag, which can drive an interrupt. The host acknowledges the message by writing the status register.

Both byte streams are valid/ready. On the outgoing stream the block holds `tx_valid` and `tx_data` steady until `tx_ready` is seen, so the coprocessor may stall it indefinitely. On the incoming stream the block raises `rx_ready` only when it can take a byte, and a byte moves only in a cycle where `rx_valid` and `rx_ready` are both high. The coprocessor must hold its byte until then. Register reads are combinational.

Top module: `msg_mailbox`

## Requirements
- R1: Register address 0 is the control register. Bit 0 is the enable and bit 1 is the interrupt enable. A read returns those two bits in the same positions, with all other bits zero.
- R2: Register address 1 is the status register. A read returns message-received at bit 7 and the current `cop_rts` level at bit 6, with all other bits zero.
- R3: A write of any value to address 1 clears message-received when enable is set. When enable is clear, the write has no effect.
- R4: A write to address 2 (send) while enabled and idle clears message-sent. The block then streams the byte at slot offset 0 (the length L), followed by the L bytes at offsets 1..L, and sets message-sent after the last byte is accepted. A read of address 2 returns message-sent at bit 7. A send write while disabled has no effect.
- R5: Address 3 selects the receive slot and address 4 selects the transmit slot. Each select is 2 bits wide, is read back in bits 1:0, and places the slot at byte address select×256.
- R6: A reception starts only when enable is set, `cop_rts` is high and message-received is clear. The first byte received is the length and is stored at slot offset 0. The next L bytes are stored at offsets 1..L. Message-received is then set.
- R7: `irq` is high exactly while interrupt enable and message-received are both set.
- R8: Reset clears enable, interrupt enable, message-received, message-sent and both slot selects, and leaves both streams idle.
- R9: A length of 0 completes after the length byte alone, in either direction, and still sets its flag.
- R10: The sequencers have priority on the buffer RAM. `ram_gnt` is low in any cycle where a sequencer uses the RAM, and a stalled host holds its request. Host read data appears on `ram_rdata` in the cycle after the granted edge.
- R11: A send write while a transmission is in progress is ignored, so only one message is streamed.
- R12: `tx_valid` and `tx_data` stay unchanged until accepted. An incoming byte is consumed only when `rx_valid` and `rx_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ram_req | input | 1 | Host buffer access request |
| ram_we | input | 1 | Host access is a write |
| ram_addr | input | 11 | Host buffer byte address |
| ram_wdata | input | 8 | Host buffer write data |
| ram_rdata | output | 8 | Host buffer read data, one cycle after grant |
| ram_gnt | output | 1 | Host access performed at this edge |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Coprocessor accepts outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Block can accept incoming byte |
| rx_data | input | 8 | Incoming byte |
| cop_rts | input | 1 | Coprocessor has a message ready |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 8-bit data, an 11-bit buffer address and 2-bit slot selects. With four slots, the sweep can visit every slot in both directions. For each slot it covers lengths 0 to 6, with the outgoing stream alternately stalled and free, and with gaps on the incoming stream. A 255-byte transmission fills the largest slot. It also keeps the transmit sequencer on the RAM for long enough that host reads beyond the slot area collide with it and must stall.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_SEND = 3'd2,
    REG_RXSL = 3'd3,
    REG_TXSL = 3'd4
  } reg_id_e;

  typedef enum logic [1:0] {
    TX_IDLE, TX_FETCH, TX_LOAD, TX_SEND
  } tx_st_e;

  typedef enum logic [1:0] {
    RX_IDLE, RX_GET, RX_STORE
  } rx_st_e;
endpackage

// File: rtl/mbx_ram.sv
module mbx_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    q <= mem[addr];
    end
  end
endmodule

// File: rtl/mbx_tx_seq.sv
module mbx_tx_seq
  import mbx_pkg::*;
#(
  parameter int AW    = 11,
  parameter int DW    = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] slot,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_gnt,
  input  logic [DW-1:0]    mem_q,
  output logic             tx_valid,
  output logic [DW-1:0]    tx_data,
  input  logic             tx_ready,
  output logic             busy,
  output logic             done
);
  tx_st_e          st_q;
  logic [SEL_W-1:0] base_q;
  logic [DW-1:0]    idx_q, len_q, byte_q;

  assign mem_req  = (st_q == TX_FETCH);
  assign mem_addr = AW'({base_q, idx_q});
  assign tx_valid = (st_q == TX_SEND);
  assign tx_data  = byte_q;
  assign busy     = (st_q != TX_IDLE);
  assign done     = tx_valid && tx_ready && (idx_q == len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      base_q <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      byte_q <= '0;
    end else begin
      case (st_q)
        TX_IDLE: if (start) begin
          base_q <= slot;
          idx_q  <= '0;
          st_q   <= TX_FETCH;
        end
        TX_FETCH: if (mem_gnt) st_q <= TX_LOAD;
        TX_LOAD: begin
          byte_q <= mem_q;
          if (idx_q == '0) len_q <= mem_q;
          st_q <= TX_SEND;
        end
        TX_SEND: if (tx_ready) begin
          if (idx_q == len_q) st_q <= TX_IDLE;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= TX_FETCH;
          end
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_rx_seq.sv
module mbx_rx_seq
  import mbx_pkg::*;
#(
  parameter int AW    = 11,
  parameter int DW    = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] slot,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_gnt,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [DW-1:0]    rx_data,
  output logic             done
);
  rx_st_e           st_q;
  logic [SEL_W-1:0] base_q;
  logic [DW-1:0]    idx_q, len_q, byte_q;
  logic             last;

  assign mem_req   = (st_q == RX_STORE);
  assign mem_addr  = AW'({base_q, idx_q});
  assign mem_wdata = byte_q;
  assign rx_ready  = (st_q == RX_GET);
  assign last      = (idx_q == '0) ? (byte_q == '0) : (idx_q == len_q);
  assign done      = mem_req && mem_gnt && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      base_q <= '0;
      idx_q  <= '0;
      len_q  <= '0;
      byte_q <= '0;
    end else begin
      case (st_q)
        RX_IDLE: if (start) begin
          base_q <= slot;
          idx_q  <= '0;
          st_q   <= RX_GET;
        end
        RX_GET: if (rx_valid) begin
          byte_q <= rx_data;
          st_q   <= RX_STORE;
        end
        RX_STORE: if (mem_gnt) begin
          if (idx_q == '0) len_q <= byte_q;
          if (last) st_q <= RX_IDLE;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= RX_GET;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
  import mbx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 11,
  parameter int SEL_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ram_req,
  input  logic          ram_we,
  input  logic [AW-1:0] ram_addr,
  input  logic [DW-1:0] ram_wdata,
  output logic [DW-1:0] ram_rdata,
  output logic          ram_gnt,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          cop_rts,
  output logic          irq
);
  logic             en_q, ie_q, recv_q, sent_q;
  logic [SEL_W-1:0] rx_sel_q, tx_sel_q;
  logic             tx_busy, tx_done, rx_done, send_acc;
  logic             tx_mem_req, rx_mem_req;
  logic [AW-1:0]    tx_mem_addr, rx_mem_addr;
  logic [DW-1:0]    rx_mem_wdata, mem_q;
  logic             mem_en, mem_we;
  logic [AW-1:0]    mem_addr;
  logic [DW-1:0]    mem_wdata;
  wire              unused_wdata = ^reg_wdata[DW-1:2];

  // Buffer port arbitration: receive, then transmit, then host
  assign ram_gnt = ram_req && !rx_mem_req && !tx_mem_req;
  always_comb begin
    mem_en    = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = ram_addr;
    mem_wdata = ram_wdata;
    if (rx_mem_req) begin
      mem_we    = 1'b1;
      mem_addr  = rx_mem_addr;
      mem_wdata = rx_mem_wdata;
    end else if (tx_mem_req) begin
      mem_addr  = tx_mem_addr;
    end else begin
      mem_en    = ram_req;
      mem_we    = ram_we;
    end
  end
  assign ram_rdata = mem_q;

  mbx_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .en(mem_en), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .q(mem_q)
  );

  assign send_acc = reg_we && (reg_addr == REG_SEND) && en_q && !tx_busy;

  mbx_tx_seq #(.AW(AW), .DW(DW), .SEL_W(SEL_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(send_acc), .slot(tx_sel_q),
    .mem_req(tx_mem_req), .mem_addr(tx_mem_addr),
    .mem_gnt(tx_mem_req && !rx_mem_req), .mem_q(mem_q),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .busy(tx_busy), .done(tx_done)
  );

  mbx_rx_seq #(.AW(AW), .DW(DW), .SEL_W(SEL_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(en_q && cop_rts && !recv_q),
    .slot(rx_sel_q), .mem_req(rx_mem_req), .mem_addr(rx_mem_addr),
    .mem_wdata(rx_mem_wdata), .mem_gnt(rx_mem_req),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .done(rx_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      recv_q   <= 1'b0;
      sent_q   <= 1'b0;
      rx_sel_q <= '0;
      tx_sel_q <= '0;
    end else begin
      if (reg_we && reg_addr == REG_CTRL) begin
        en_q <= reg_wdata[0];
        ie_q <= reg_wdata[1];
      end
      if (reg_we && reg_addr == REG_RXSL) rx_sel_q <= reg_wdata[SEL_W-1:0];
      if (reg_we && reg_addr == REG_TXSL) tx_sel_q <= reg_wdata[SEL_W-1:0];
      if (rx_done) recv_q <= 1'b1;
      else if (reg_we && reg_addr == REG_STAT && en_q) recv_q <= 1'b0;
      if (send_acc) sent_q <= 1'b0;
      else if (tx_done) sent_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CTRL: reg_rdata = DW'({ie_q, en_q});
      REG_STAT: begin
        reg_rdata[DW-1] = recv_q;
        reg_rdata[DW-2] = cop_rts;
      end
      REG_SEND: reg_rdata[DW-1] = sent_q;
      REG_RXSL: reg_rdata = DW'(rx_sel_q);
      REG_TXSL: reg_rdata = DW'(tx_sel_q);
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = ie_q && recv_q;
endmodule

// File: rtl/msg_mailbox_chk.sv
module msg_mailbox_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          rx_ready,
  input logic          ram_gnt,
  input logic          rx_mem_req,
  input logic          tx_mem_req,
  input logic          recv_q,
  input logic          sent_q,
  input logic          en_q,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic          irq
);
  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R10
  host_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mem_req || tx_mem_req) |-> !ram_gnt);

  // R6
  recv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recv_q) |-> $past(rx_mem_req));

  // R3
  recv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(recv_q) |-> $past(en_q && reg_we && reg_addr == 3'd1));

  // R4
  sent_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sent_q) |-> $past(en_q && reg_we && reg_addr == 3'd2));

  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !rx_ready);
endmodule

bind msg_mailbox msg_mailbox_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .rx_ready(rx_ready), .ram_gnt(ram_gnt),
  .rx_mem_req(rx_mem_req), .tx_mem_req(tx_mem_req), .recv_q(recv_q),
  .sent_q(sent_q), .en_q(en_q), .reg_we(reg_we), .reg_addr(reg_addr),
  .irq(irq)
);

// File: tb/msg_mailbox_test.sv
`timescale 1ns/1ps
module msg_mailbox_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  reg_addr = 0;
  logic        reg_we = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        ram_req = 0, ram_we = 0;
  logic [10:0] ram_addr = 0;
  logic [7:0]  ram_wdata = 0;
  logic [7:0]  ram_rdata;
  logic        ram_gnt;
  logic        tx_valid;
  logic        tx_ready = 0;
  logic [7:0]  tx_data;
  logic        rx_valid = 0;
  logic        rx_ready;
  logic [7:0]  rx_data = 0;
  logic        cop_rts = 0;
  logic        irq;

  int checks = 0, errors = 0;
  int ncap = 0, stalls = 0, rdy_cnt = 0;
  bit bp_mode = 0;
  bit finished = 0;
  logic [7:0] cap [0:299];

  always #2.5 clk = ~clk;

  msg_mailbox uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ram_req(ram_req),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .ram_gnt(ram_gnt), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .cop_rts(cop_rts), .irq(irq)
  );

  function automatic logic [7:0] pat(int s, int i, int l);
    return 8'((s * 61 + i * 7 + l * 3 + 5) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Outgoing-stream sink: ready pattern set at the falling edge, capture
  // of the byte that the next rising edge will transfer
  initial forever begin
    @(negedge clk);
    rdy_cnt++;
    tx_ready = bp_mode ? (rdy_cnt % 3 != 0) : 1'b1;
    #1;
    if (tx_valid && tx_ready && ncap < 300) begin
      cap[ncap] = tx_data;
      ncap++;
    end
  end

  task automatic reg_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ram_wr(int a, logic [7:0] d);
    @(negedge clk);
    ram_req = 1; ram_we = 1; ram_addr = 11'(a); ram_wdata = d;
    #1;
    while (!ram_gnt) begin stalls++; @(negedge clk); #1; end
    @(negedge clk);
    ram_req = 0; ram_we = 0;
  endtask

  task automatic ram_rd(int a, output logic [7:0] d);
    @(negedge clk);
    ram_req = 1; ram_we = 0; ram_addr = 11'(a);
    #1;
    while (!ram_gnt) begin stalls++; @(negedge clk); #1; end
    @(negedge clk);
    ram_req = 0;
    #1 d = ram_rdata;
  endtask

  task automatic wait_bit(logic [2:0] a, output bit ok);
    logic [7:0] d;
    ok = 0;
    for (int n = 0; n < 3000; n++) begin
      reg_rd(a, d);
      if (d[7]) begin ok = 1; break; end
    end
  endtask

  task automatic rx_msg(int s, int l);
    logic [7:0] b;
    cop_rts = 1;
    for (int i = 0; i <= l; i++) begin
      b = (i == 0) ? 8'(l) : (pat(s, i, l) ^ 8'h5A);
      if (i % 2 == 1) begin @(negedge clk); rx_valid = 0; end
      @(negedge clk);
      rx_valid = 1; rx_data = b;
      #1;
      while (!rx_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    rx_valid = 0; cop_rts = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R8: reset state
    for (int a = 0; a < 5; a++) begin
      reg_rd(3'(a), d);
      chk(d == 8'h00, "R8 reset reg", d, 0);
    end
    chk(irq == 0 && tx_valid == 0 && rx_ready == 0, "R8 reset outputs",
        {irq, tx_valid, rx_ready}, 0);

    // R1: control readback
    reg_wr(0, 8'hFF); reg_rd(0, d); chk(d == 8'h03, "R1 ctrl all", d, 3);
    reg_wr(0, 8'h02); reg_rd(0, d); chk(d == 8'h02, "R1 ctrl ie", d, 2);
    reg_wr(0, 8'h00); reg_rd(0, d); chk(d == 8'h00, "R1 ctrl clr", d, 0);

    // R2 and R6 gating: data-ready visible, no reception while disabled
    cop_rts = 1;
    repeat (4) @(negedge clk);
    reg_rd(1, d); chk(d == 8'h40, "R2 status rts", d, 8'h40);
    chk(rx_ready == 0, "R6 no start when disabled", rx_ready, 0);
    cop_rts = 0;
    reg_rd(1, d); chk(d == 8'h00, "R2 status idle", d, 0);

    // R4: send while disabled is ignored
    ncap = 0;
    reg_wr(2, 0);
    repeat (10) @(negedge clk);
    chk(ncap == 0, "R4 send disabled stream", ncap, 0);
    reg_rd(2, d); chk(d == 8'h00, "R4 send disabled flag", d, 0);

    // R5: slot selects read back
    reg_wr(3, 8'hFE); reg_rd(3, d); chk(d == 8'h02, "R5 rx select", d, 2);
    reg_wr(4, 8'hFD); reg_rd(4, d); chk(d == 8'h01, "R5 tx select", d, 1);

    // R4, R5, R9, R12: transmit sweep over slots and lengths
    reg_wr(0, 8'h01);
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 7; l++) begin
        ram_wr(s * 256, 8'(l));
        for (int i = 1; i <= l; i++) ram_wr(s * 256 + i, pat(s, i, l));
        reg_wr(4, 8'(s));
        bp_mode = (l % 2 == 1);
        ncap = 0;
        reg_wr(2, 0);
        reg_rd(2, d); chk(d == 8'h00, "R4 sent cleared", d, 0);
        wait_bit(2, ok);
        chk(ok, (l == 0) ? "R9 tx zero length sent" : "R4 sent set", ok, 1);
        chk(ncap == l + 1, "R4 R12 byte count", ncap, l + 1);
        chk(cap[0] == 8'(l), "R5 length byte from slot", cap[0], l);
        for (int i = 1; i <= l && i < ncap; i++)
          chk(cap[i] == pat(s, i, l), "R4 payload byte", cap[i], pat(s, i, l));
      end
    end

    // R11: send write during transmission ignored
    bp_mode = 1;
    ram_wr(256, 8'd20);
    for (int i = 1; i <= 20; i++) ram_wr(256 + i, 8'(i));
    reg_wr(4, 1);
    ncap = 0;
    reg_wr(2, 0);
    reg_wr(2, 0);
    wait_bit(2, ok);
    repeat (80) @(negedge clk);
    chk(ncap == 21, "R11 single message", ncap, 21);

    // R10: host reads collide with a long transmission
    bp_mode = 0;
    for (int i = 0; i < 40; i++) ram_wr(1024 + i, 8'(i * 5 + 1));
    ram_wr(512, 8'd255);
    for (int i = 1; i <= 255; i++) ram_wr(512 + i, pat(2, i, 255));
    reg_wr(4, 2);
    ncap = 0;
    stalls = 0;
    reg_wr(2, 0);
    for (int i = 0; i < 40; i++) begin
      ram_rd(1024 + i, d);
      chk(d == 8'(i * 5 + 1), "R10 host read", d, i * 5 + 1);
    end
    chk(stalls > 0, "R10 host stalled", stalls, 1);
    wait_bit(2, ok);
    chk(ok && ncap == 256, "R4 long message count", ncap, 256);
    for (int i = 1; i < 256 && i < ncap; i++)
      if (cap[i] != pat(2, i, 255))
        chk(0, "R4 long payload", cap[i], pat(2, i, 255));

    // R3, R6, R7, R9, R12: receive sweep
    reg_wr(0, 8'h03);
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 7; l++) begin
        reg_wr(3, 8'(s));
        rx_msg(s, l);
        wait_bit(1, ok);
        chk(ok, (l == 0) ? "R9 rx zero length received" : "R6 received", ok, 1);
        chk(irq == 1, "R7 irq asserted", irq, 1);
        ram_rd(s * 256, d); chk(d == 8'(l), "R6 length stored", d, l);
        for (int i = 1; i <= l; i++) begin
          ram_rd(s * 256 + i, d);
          chk(d == (pat(s, i, l) ^ 8'h5A), "R6 payload stored", d,
              pat(s, i, l) ^ 8'h5A);
        end
        if (s == 0 && l == 2) begin
          reg_wr(0, 8'h01);
          chk(irq == 0, "R7 irq masked", irq, 1'b0);
          reg_wr(0, 8'h02);
          reg_wr(1, 8'h00);
          reg_rd(1, d); chk(d == 8'h80, "R3 clear ignored when disabled", d, 8'h80);
          chk(irq == 1, "R7 irq held", irq, 1);
          reg_wr(0, 8'h03);
        end
        reg_wr(1, 8'h5C);
        reg_rd(1, d); chk(d == 8'h00, "R3 status cleared", d, 0);
        chk(irq == 0, "R7 irq dropped", irq, 0);
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule